// File: doc/BRIEF.md
# Continuous-Phase AFSK Tone Generator

The block synthesizes the audio for a 1200 baud audio-frequency-shift-keyed transmitter as a stream of 8-bit unsigned samples for a DAC. A timebase counter produces a sample strobe every 19 clocks. On each strobe an 8-bit phase accumulator advances by one of two step sizes, chosen by the data bit present at that strobe. The small step gives the low tone (near 1200 Hz) and the large step gives the high tone (near 2200 Hz) at the intended sample rate.

The magnitude of each sample comes from a 128-entry half-sine table that is indexed by the low seven phase bits. The top phase bit chooses whether that magnitude is added to mid-scale (0x80) or subtracted from it. Transmission runs while the active-low push-to-talk input is low. While it is high, the output rests at a fixed bias code and the phase stays frozen. The phase is never cleared on a tone change or at the end of a transmission, so the waveform stays continuous.

Top module: `afsk_tone_gen`

## Requirements
- R1: While reset is asserted and after it is released, `dac_sample` reads 0x73 and the phase is 0. The first transmitted sample is therefore based on phase 0 plus one step.
- R2: While `ptt_n` is high, `dac_sample` is 0x73 from the first rising edge at which `ptt_n` is seen high. `data_bit` has no effect on it.
- R3: The sample strobe fires on the 19th rising edge after `ptt_n` is first sampled low, and then on every 19th edge. `dac_sample` changes only on a strobe edge.
- R4: On a strobe with `data_bit` = 0, the phase advances by 0x10 modulo 256.
- R5: On a strobe with `data_bit` = 1, the phase advances by 0x1E modulo 256.
- R6: The table value for index i (the low 7 phase bits) is round(63·sin(π·i/128)). The peak value 0x3F is reached at i = 64, so phase 0x40 gives a sample of 0xBF.
- R7: When phase bit 7 is 0, the sample is 0x80 plus the table value. When phase bit 7 is 1, the sample is 0x80 minus the table value (phase 0xC0 gives 0x41). The sample is computed from the phase after that strobe's step.
- R8: The phase is never cleared by a tone change or by the end of a transmission. After an idle period, transmission resumes from the phase it had when it stopped.
- R9: `data_bit` is sampled on the strobe edge itself. A change made just before that edge selects the step for that edge's sample.
- R10: `dac_sample` always lies within 0x41 to 0xBF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptt_n | input | 1 | Active-low push-to-talk; low means transmit |
| data_bit | input | 1 | Tone select: 0 low tone, 1 high tone |
| dac_sample | output | 8 | Unsigned sample for the DAC, 0x73 while idle |

## Verification
Two events can land on the same clock edge: the sample strobe and a change of one of the controls. The first case is a push-to-talk release or a tone flip that arrives on the strobe edge itself. The bench raises `ptt_n` at the falling edge just before a strobe. It then checks that the bias code appears and that the phase did not advance, by resuming later and comparing the next sample against a model that skipped that strobe. It also flips `data_bit` just before a strobe and checks that the new step governs that very sample. Every sample is compared exactly against a model with its own sine computation.

// File: rtl/afsk_pkg.sv
package afsk_pkg;

  // Rounded magnitude of a half sine: peak * sin(pi * idx / half_len)
  function automatic int half_sine_mag(input int idx, input int half_len, input int peak);
    real ang;
    ang = 3.141592653589793 * real'(idx) / real'(half_len);
    return int'(real'(peak) * $sin(ang));
  endfunction

  // Fold a magnitude around mid-scale according to the sign bit
  function automatic logic [7:0] fold_about_mid(input logic neg, input logic [7:0] mag);
    logic [7:0] mid;
    mid = 8'h80;
    return neg ? (mid - mag) : (mid + mag);
  endfunction

endpackage

// File: rtl/afsk_timebase.sv
module afsk_timebase #(
  parameter int CNT_W  = 8,
  parameter int RELOAD = 'hED
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_on,
  output logic strobe
);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(RELOAD);
  localparam logic [CNT_W-1:0] TOP_V  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  assign strobe = tx_on && (cnt == TOP_V);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= LOAD_V;
    else if (!tx_on)  cnt <= LOAD_V;
    else if (strobe)  cnt <= LOAD_V;
    else              cnt <= cnt + 1'b1;
  end

  // R3: strobes never come back to back
  assert_strobe_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

endmodule

// File: rtl/afsk_phase_acc.sv
module afsk_phase_acc #(
  parameter int PHASE_W = 8,
  parameter int STEP_LO = 'h10,
  parameter int STEP_HI = 'h1E
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  logic               tone_hi,
  output logic [PHASE_W-1:0] phase_next,
  output logic               phase_wrap
);
  localparam logic [PHASE_W-1:0] INC_LO = PHASE_W'(STEP_LO);
  localparam logic [PHASE_W-1:0] INC_HI = PHASE_W'(STEP_HI);

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] inc;
  logic               carry;

  assign inc = tone_hi ? INC_HI : INC_LO;
  assign {carry, phase_next} = {1'b0, phase} + {1'b0, inc};
  assign phase_wrap = strobe && carry;

  always_ff @(posedge clk) begin
    if (!rst_n)      phase <= '0;
    else if (strobe) phase <= phase_next;
  end

  // R4: low-tone step
  assert_step_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !tone_hi) |=> (phase == PHASE_W'($past(phase) + INC_LO)));
  // R5: high-tone step
  assert_step_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && tone_hi) |=> (phase == PHASE_W'($past(phase) + INC_HI)));
  // R8: phase frozen between strobes and while idle
  assert_phase_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(phase));

endmodule

// File: rtl/afsk_sine_rom.sv
module afsk_sine_rom #(
  parameter int IDX_W = 7,
  parameter int MAG_W = 6,
  parameter int PEAK  = 63
) (
  input  logic [IDX_W-1:0] idx,
  output logic [MAG_W-1:0] mag
);
  localparam int DEPTH = 1 << IDX_W;

  logic [MAG_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam logic [MAG_W-1:0] VAL = MAG_W'(afsk_pkg::half_sine_mag(i, DEPTH, PEAK));
    assign rom[i] = VAL;
  end

  assign mag = rom[idx];

  // R6: no entry exceeds the peak
  always_comb begin
    assert_mag_peak_R6: assert (int'(mag) <= PEAK);
  end

endmodule

// File: rtl/afsk_sample_fold.sv
module afsk_sample_fold #(
  parameter int MAG_W     = 6,
  parameter int PEAK      = 63,
  parameter int IDLE_CODE = 'h73
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_on,
  input  logic             strobe,
  input  logic             neg,
  input  logic [MAG_W-1:0] mag,
  output logic [7:0]       sample
);
  localparam logic [7:0] IDLE_V = 8'(IDLE_CODE);
  localparam logic [7:0] LO_V   = 8'(128 - PEAK);
  localparam logic [7:0] HI_V   = 8'(128 + PEAK);

  always_ff @(posedge clk) begin
    if (!rst_n)      sample <= IDLE_V;
    else if (!tx_on) sample <= IDLE_V;
    else if (strobe) sample <= afsk_pkg::fold_about_mid(neg, 8'(mag));
  end

  // R3: output changes only on strobe while transmitting
  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_on && !strobe) |=> $stable(sample));
  // R10: output range
  assert_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample >= LO_V) && (sample <= HI_V));

endmodule

// File: rtl/afsk_tone_gen.sv
module afsk_tone_gen #(
  parameter int CNT_W     = 8,
  parameter int RELOAD    = 'hED,
  parameter int PHASE_W   = 8,
  parameter int STEP_LO   = 'h10,
  parameter int STEP_HI   = 'h1E,
  parameter int MAG_W     = 6,
  parameter int PEAK      = 63,
  parameter int IDLE_CODE = 'h73
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ptt_n,
  input  logic       data_bit,
  output logic [7:0] dac_sample
);
  localparam int IDX_W = PHASE_W - 1;

  logic               tx_on;
  logic               strobe;
  logic [PHASE_W-1:0] phase_next;
  logic               phase_wrap;
  logic [MAG_W-1:0]   mag;

  assign tx_on = !ptt_n;

  afsk_timebase #(.CNT_W(CNT_W), .RELOAD(RELOAD)) u_timebase (
    .clk(clk), .rst_n(rst_n), .tx_on(tx_on), .strobe(strobe)
  );

  afsk_phase_acc #(.PHASE_W(PHASE_W), .STEP_LO(STEP_LO), .STEP_HI(STEP_HI)) u_phase (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .tone_hi(data_bit),
    .phase_next(phase_next), .phase_wrap(phase_wrap)
  );

  afsk_sine_rom #(.IDX_W(IDX_W), .MAG_W(MAG_W), .PEAK(PEAK)) u_rom (
    .idx(phase_next[IDX_W-1:0]), .mag(mag)
  );

  afsk_sample_fold #(.MAG_W(MAG_W), .PEAK(PEAK), .IDLE_CODE(IDLE_CODE)) u_fold (
    .clk(clk), .rst_n(rst_n), .tx_on(tx_on), .strobe(strobe),
    .neg(phase_next[PHASE_W-1]), .mag(mag), .sample(dac_sample)
  );

  // R7: after a wrap the new phase is in the positive half
  assert_wrap_positive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    phase_wrap |=> (dac_sample >= 8'h80));
  // R2: idle drives the bias code
  assert_idle_bias_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ptt_n && $past(ptt_n)) |-> (dac_sample == 8'(IDLE_CODE)));

endmodule

// File: tb/test_afsk_tone_gen.sv
module test_afsk_tone_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ptt_n = 1'b1;
  logic       data_bit = 1'b0;
  logic [7:0] dac_sample;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit [7:0] mph = 8'h00;

  localparam int NSEG = 6;
  localparam bit SEG_DATA [NSEG] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int SEG_LEN  [NSEG] = '{16, 9, 5, 12, 3, 20};

  always #10 clk = ~clk;

  afsk_tone_gen i_afsk_tone_gen (
    .clk(clk), .rst_n(rst_n), .ptt_n(ptt_n), .data_bit(data_bit),
    .dac_sample(dac_sample)
  );

  function automatic bit [7:0] model_sample(input bit [7:0] ph);
    real x;
    int  m;
    x = 63.0 * $sin(3.141592653589793 * real'(ph[6:0]) / 128.0);
    m = $rtoi(x + 0.5);
    return ph[7] ? 8'(128 - m) : 8'(128 + m);
  endfunction

  task automatic check(input string req, input bit [7:0] act, input bit [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input bit [7:0] act);
    checks++;
    if (act < 8'h41 || act > 8'hBF) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x41..0xBF", req, act);
    end
  endtask

  // Wait one strobe period, advance the model, compare
  task automatic next_sample(input string req);
    repeat (19) @(posedge clk);
    @(negedge clk);
    mph = mph + (data_bit ? 8'h1E : 8'h10);
    check(req, dac_sample, model_sample(mph));
    check_range("R10", dac_sample);
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset output", dac_sample, 8'h73);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 idle code", dac_sample, 8'h73);
    data_bit = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R2 data ignored while idle", dac_sample, 8'h73);
    data_bit = 1'b0;

    // R3: first strobe on the 19th edge after ptt low
    ptt_n = 1'b0;
    repeat (18) @(posedge clk);
    @(negedge clk);
    check("R3 no sample before 19th edge", dac_sample, 8'h73);
    @(posedge clk);
    @(negedge clk);
    mph = 8'h10;
    check("R1 first sample from phase 0", dac_sample, model_sample(mph));
    repeat (18) @(posedge clk);
    @(negedge clk);
    check("R3 held between strobes", dac_sample, model_sample(mph));
    @(posedge clk);
    @(negedge clk);
    mph = mph + 8'h10;
    check("R4 low step", dac_sample, model_sample(mph));
    next_sample("R4 low step");
    next_sample("R6 peak at phase 0x40");
    check("R6 peak value", dac_sample, 8'hBF);
    repeat (8) next_sample("R7 sign fold");
    check("R7 trough at phase 0xC0", dac_sample, 8'h41);

    // Vector table walk
    for (int s = 0; s < NSEG; s++) begin
      data_bit = SEG_DATA[s];
      for (int k = 0; k < SEG_LEN[s]; k++)
        next_sample(SEG_DATA[s] ? "R5 high step" : "R4 low step");
    end

    // R9: data flip just before strobe edge governs that sample
    data_bit = 1'b0;
    repeat (18) @(posedge clk);
    @(negedge clk);
    data_bit = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mph = mph + 8'h1E;
    check("R9 late data flip", dac_sample, model_sample(mph));

    // R2/R8: ptt release on the strobe cycle, then resume
    repeat (18) @(posedge clk);
    @(negedge clk);
    ptt_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2 release on strobe edge", dac_sample, 8'h73);
    data_bit = 1'b0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R2 idle hold", dac_sample, 8'h73);
    ptt_n = 1'b0;
    next_sample("R8 phase kept across idle");
    next_sample("R8 continuity");

    // R8: tone change without phase reset
    data_bit = 1'b1;
    next_sample("R8 tone change continuity");

    done = 1;
    finish_run();
  end

endmodule